// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves data between system memory and a disk device's data port without processor involvement. Software places a table of region descriptors in memory, writes the table's physical address into a pointer register, then writes the command register once with both the direction and the start bit. The engine reads one descriptor at a time. Each descriptor gives the start address and byte count of one contiguous region. The engine then moves that region one 16-bit halfword at a time. Each halfword passes through a simple request/acknowledge handshake with the device on one side and single-beat memory read or write ports on the other.

After the descriptor flagged as the end of the table has been transferred, the engine goes idle and raises a sticky interrupt latch. A memory error response, or a descriptor fetch that would leave the table's 4 KB page, raises a sticky error latch instead. Software polls or clears both latches through the status register. Any command write with the start bit clear throws away everything the engine was doing.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the command, status and table-pointer registers read zero, `irq` is low and none of `mrd_req`, `mwr_req`, `dev_req` is asserted.
- R2: A descriptor is two 32-bit words at consecutive addresses. The first is the region address, with bits 1:0 ignored (treated as zero). The second is the count word: bit 31 marks the last descriptor, bits 15:1 hold the byte count divided by two, and bit 0 and bits 30:16 are ignored. Regions are processed in table order, and halfwords within a region go to ascending addresses in steps of 2.
- R3: A count word whose bits 15:1 are all zero describes a region of 65536 bytes (32768 halfwords).
- R4: With command bit 3 set (device to memory), each halfword taken on a `dev_req`/`dev_ack` handshake is written on the memory write port. `mwr_addr` is the word address, `mwr_data` carries the halfword in both lanes, and `mwr_be` is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R5: With command bit 3 clear (memory to device), each halfword is read as a 32-bit word at its word address. The lower lane is used when address bit 1 is 0 and the upper lane when it is 1. The halfword is presented on `dev_dout` during the device handshake.
- R6: When the last halfword of the region flagged as the last descriptor completes, status bit 2 (interrupt) sets, status bit 0 (active) clears, and no further descriptor is fetched.
- R7: Register offsets are 0 = command, 1 = status, 2 = table pointer. A command write with bit 0 set starts the engine only if the stored start bit is clear, and it captures bit 3 as the direction. A command write with bit 0 set while the start bit is already set changes neither the transfer nor the direction. A command write with bit 0 clear stops the engine: in the next cycle it is idle with no request asserted, and the next start begins again at the first descriptor.
- R8: The table-pointer register ignores bits 1:0 of a write and reads them back as zero. Fetching starts at the masked address.
- R9: If a descriptor word fetch would fall outside the 4 KB page holding the table base, the engine issues no read for it. It sets status bit 1 (error), leaves status bit 2 unchanged, and goes idle.
- R10: An error response (`mrd_err` with `mrd_ack`) on a descriptor or data read sets status bit 1 and stops the engine without setting status bit 2.
- R11: Status bits 1 and 2 are cleared only by writing one to them. A status write with zero in a latch bit, whatever the other bits hold, leaves that latch unchanged.
- R12: `dev_irq` high in any cycle sets status bit 2. `irq` always equals status bit 2.
- R13: At most one of `mrd_req`, `mwr_req`, `dev_req` is high at a time. A memory read request keeps its address until it is acknowledged, unless the engine is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command, 1 status, 2 table pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | 32 | Memory read word address |
| mrd_ack | input | 1 | Memory read acknowledge, data valid |
| mrd_data | input | 32 | Memory read data |
| mrd_err | input | 1 | Error response qualifying `mrd_ack` |
| mwr_req | output | 1 | Memory write request |
| mwr_addr | output | 32 | Memory write word address |
| mwr_data | output | 32 | Memory write data, halfword in both lanes |
| mwr_be | output | 4 | Memory write byte enables |
| mwr_ack | input | 1 | Memory write acknowledge |
| dev_req | output | 1 | Device halfword handshake request |
| dev_ack | input | 1 | Device handshake acknowledge |
| dev_din | input | 16 | Halfword from the device (device to memory) |
| dev_dout | output | 16 | Halfword to the device (memory to device) |
| dev_irq | input | 1 | Device interrupt, sets the interrupt latch |
| irq | output | 1 | Interrupt latch output |

## Verification
The properties assume that every acknowledge arrives only while its own request is high, and that software never changes the table while a transfer is running. The bench models memory and device combinationally from the request signals, so no acknowledge can appear without its request. It changes tables only while the engine is idle, and random stalls on the three acknowledges are the only source of timing variation. Read-address stability is checked only in runs that are not deliberately aborted, because a stop is allowed to withdraw a pending read.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned HALF_W    = 16;
    localparam int unsigned EOT_BIT   = 31;
    localparam int unsigned CMD_GO    = 0;
    localparam int unsigned CMD_DIR   = 3;
    localparam int unsigned STS_BUSY  = 0;
    localparam int unsigned STS_FAULT = 1;
    localparam int unsigned STS_DONE  = 2;

    typedef enum logic [1:0] {
        SEL_CMD    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_TABLE  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_DESC_ADDR,
        WK_DESC_CNT,
        WK_MEM_RD,
        WK_DEV,
        WK_MEM_WR
    } walk_state_e;

    // control handed from the register block to the walker
    typedef struct packed {
        logic go;
        logic halt;
        logic to_mem;
    } walk_ctl_t;

    // events reported back by the walker
    typedef struct packed {
        logic busy;
        logic finished;
        logic fault;
    } walk_evt_t;

    // halfwords in one region; an all-zero count field means the full 64 KB
    function automatic logic [HALF_W-1:0] region_halfwords(input logic [WORD_W-1:0] cw);
        logic [HALF_W-2:0] h;
        h = cw[HALF_W-1:1];
        return (h == '0) ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, h};
    endfunction

    function automatic logic [HALF_W-1:0] lane_pick(input logic [WORD_W-1:0] w, input logic upper);
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic logic [3:0] lane_enables(input logic upper);
        return upper ? 4'b1100 : 4'b0011;
    endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                dev_irq,
    input  walk_evt_t           evt,
    output walk_ctl_t           ctl,
    output logic [WORD_W-3:0]   table_base,
    output logic                irq
);

    logic              start_q;
    logic              dir_q;
    logic [WORD_W-3:0] base_q;
    logic              done_q;
    logic              fault_q;

    logic wr_cmd, wr_sts, wr_tbl;
    logic clr_done, clr_fault;

    assign wr_cmd    = reg_wr && (reg_sel_e'(reg_addr) == SEL_CMD);
    assign wr_sts    = reg_wr && (reg_sel_e'(reg_addr) == SEL_STATUS);
    assign wr_tbl    = reg_wr && (reg_sel_e'(reg_addr) == SEL_TABLE);
    assign clr_done  = wr_sts && reg_wdata[STS_DONE];
    assign clr_fault = wr_sts && reg_wdata[STS_FAULT];

    assign ctl.go     = wr_cmd && reg_wdata[CMD_GO] && !start_q;
    assign ctl.halt   = wr_cmd && !reg_wdata[CMD_GO];
    assign ctl.to_mem = dir_q;
    assign table_base = base_q;
    assign irq        = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            base_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (wr_cmd) start_q <= reg_wdata[CMD_GO];
            if (ctl.go) dir_q   <= reg_wdata[CMD_DIR];
            if (wr_tbl) base_q  <= reg_wdata[WORD_W-1:2];
            // a set event wins over a clear in the same cycle
            done_q  <= (done_q && !clr_done) || evt.finished || dev_irq;
            fault_q <= (fault_q && !clr_fault) || evt.fault;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_CMD: begin
                reg_rdata[CMD_GO]  = start_q;
                reg_rdata[CMD_DIR] = dir_q;
            end
            SEL_STATUS: begin
                reg_rdata[STS_BUSY]  = evt.busy;
                reg_rdata[STS_FAULT] = fault_q;
                reg_rdata[STS_DONE]  = done_q;
            end
            SEL_TABLE: reg_rdata = {base_q, 2'b00};
            default:   reg_rdata = '0;
        endcase
    end

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        done_q && !clr_done |=> done_q)
        else $error("interrupt latch lost without a one written");

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        fault_q && !clr_fault |=> fault_q)
        else $error("error latch lost without a one written");

    assert_devirq_sets_R12: assert property (@(posedge clk) disable iff (rst)
        dev_irq |=> irq)
        else $error("device interrupt not latched");

    assert_fault_latched_R10: assert property (@(posedge clk) disable iff (rst)
        evt.fault |=> fault_q)
        else $error("walker fault not latched");

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  walk_ctl_t           ctl,
    input  logic [WORD_W-3:0]   table_base,
    output walk_evt_t           evt,
    output logic                mrd_req,
    output logic [WORD_W-1:0]   mrd_addr,
    input  logic                mrd_ack,
    input  logic [WORD_W-1:0]   mrd_data,
    input  logic                mrd_err,
    output logic                mwr_req,
    output logic [WORD_W-1:0]   mwr_addr,
    output logic [WORD_W-1:0]   mwr_data,
    output logic [3:0]          mwr_be,
    input  logic                mwr_ack,
    output logic                dev_req,
    input  logic                dev_ack,
    input  logic [HALF_W-1:0]   dev_din,
    output logic [HALF_W-1:0]   dev_dout
);

    localparam int unsigned PAGE_W = WORD_W - PAGE_BITS;

    walk_state_e       state;
    logic [WORD_W-1:0] pos;
    logic [PAGE_W-1:0] page;
    logic [WORD_W-1:0] cur;
    logic [HALF_W-1:0] rem;
    logic              eot;
    logic [HALF_W-1:0] hold;

    logic              fetching;
    logic [WORD_W-1:0] fetch_addr;
    logic              crossing;
    logic              rd_fault;
    logic              beat_done;
    logic              last_beat;
    walk_state_e       after_beat;

    assign fetching   = (state == WK_DESC_ADDR) || (state == WK_DESC_CNT);
    assign fetch_addr = (state == WK_DESC_CNT) ? pos + 32'd4 : pos;
    assign crossing   = fetching && (fetch_addr[WORD_W-1:PAGE_BITS] != page);

    assign mrd_req  = (fetching && !crossing) || (state == WK_MEM_RD);
    assign mrd_addr = fetching ? fetch_addr : {cur[WORD_W-1:2], 2'b00};
    assign mwr_req  = (state == WK_MEM_WR);
    assign mwr_addr = {cur[WORD_W-1:2], 2'b00};
    assign mwr_data = {hold, hold};
    assign mwr_be   = lane_enables(cur[1]);
    assign dev_req  = (state == WK_DEV);
    assign dev_dout = hold;

    assign rd_fault  = mrd_req && mrd_ack && mrd_err;
    assign beat_done = (dev_req && dev_ack && !ctl.to_mem) || (mwr_req && mwr_ack);
    assign last_beat = (rem == {{(HALF_W-1){1'b0}}, 1'b1});

    always_comb begin
        if (!last_beat)
            after_beat = ctl.to_mem ? WK_DEV : WK_MEM_RD;
        else if (eot)
            after_beat = WK_IDLE;
        else
            after_beat = WK_DESC_ADDR;
    end

    assign evt.busy     = (state != WK_IDLE);
    assign evt.finished = !ctl.halt && beat_done && last_beat && eot;
    assign evt.fault    = !ctl.halt && (crossing || rd_fault);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_IDLE;
            pos   <= '0;
            page  <= '0;
            cur   <= '0;
            rem   <= '0;
            eot   <= 1'b0;
            hold  <= '0;
        end else if (ctl.halt) begin
            state <= WK_IDLE;
        end else begin
            unique case (state)
                WK_IDLE: if (ctl.go) begin
                    pos   <= {table_base, 2'b00};
                    page  <= table_base[WORD_W-3:PAGE_BITS-2];
                    state <= WK_DESC_ADDR;
                end
                WK_DESC_ADDR: begin
                    if (crossing) begin
                        state <= WK_IDLE;
                    end else if (mrd_ack) begin
                        if (mrd_err) begin
                            state <= WK_IDLE;
                        end else begin
                            cur   <= {mrd_data[WORD_W-1:2], 2'b00};
                            state <= WK_DESC_CNT;
                        end
                    end
                end
                WK_DESC_CNT: begin
                    if (crossing) begin
                        state <= WK_IDLE;
                    end else if (mrd_ack) begin
                        if (mrd_err) begin
                            state <= WK_IDLE;
                        end else begin
                            rem   <= region_halfwords(mrd_data);
                            eot   <= mrd_data[EOT_BIT];
                            pos   <= pos + 32'd8;
                            state <= ctl.to_mem ? WK_DEV : WK_MEM_RD;
                        end
                    end
                end
                WK_MEM_RD: if (mrd_ack) begin
                    if (mrd_err) begin
                        state <= WK_IDLE;
                    end else begin
                        hold  <= lane_pick(mrd_data, cur[1]);
                        state <= WK_DEV;
                    end
                end
                WK_DEV: if (dev_ack) begin
                    if (ctl.to_mem) begin
                        hold  <= dev_din;
                        state <= WK_MEM_WR;
                    end else begin
                        cur   <= cur + 32'd2;
                        rem   <= rem - 1'b1;
                        state <= after_beat;
                    end
                end
                WK_MEM_WR: if (mwr_ack) begin
                    cur   <= cur + 32'd2;
                    rem   <= rem - 1'b1;
                    state <= after_beat;
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    assert_one_request_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mrd_req, mwr_req, dev_req}))
        else $error("more than one request at once");

    assert_read_held_R13: assert property (@(posedge clk) disable iff (rst)
        mrd_req && !mrd_ack && !ctl.halt |=> mrd_req && $stable(mrd_addr))
        else $error("read request dropped or moved before acknowledge");

    assert_halt_flush_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.halt |=> !evt.busy && !mrd_req && !mwr_req && !dev_req)
        else $error("engine still busy after stop");

    assert_finish_idle_R6: assert property (@(posedge clk) disable iff (rst)
        evt.finished |=> !evt.busy && !mrd_req)
        else $error("engine kept going after last region");

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mrd_req,
    output logic [31:0] mrd_addr,
    input  logic        mrd_ack,
    input  logic [31:0] mrd_data,
    input  logic        mrd_err,
    output logic        mwr_req,
    output logic [31:0] mwr_addr,
    output logic [31:0] mwr_data,
    output logic [3:0]  mwr_be,
    input  logic        mwr_ack,
    output logic        dev_req,
    input  logic        dev_ack,
    input  logic [15:0] dev_din,
    output logic [15:0] dev_dout,
    input  logic        dev_irq,
    output logic        irq
);

    walk_ctl_t         ctl;
    walk_evt_t         evt;
    logic [WORD_W-3:0] table_base;

    sgdma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .dev_irq    (dev_irq),
        .evt        (evt),
        .ctl        (ctl),
        .table_base (table_base),
        .irq        (irq)
    );

    sgdma_walker #(.PAGE_BITS(PAGE_BITS)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .table_base (table_base),
        .evt        (evt),
        .mrd_req    (mrd_req),
        .mrd_addr   (mrd_addr),
        .mrd_ack    (mrd_ack),
        .mrd_data   (mrd_data),
        .mrd_err    (mrd_err),
        .mwr_req    (mwr_req),
        .mwr_addr   (mwr_addr),
        .mwr_data   (mwr_data),
        .mwr_be     (mwr_be),
        .mwr_ack    (mwr_ack),
        .dev_req    (dev_req),
        .dev_ack    (dev_ack),
        .dev_din    (dev_din),
        .dev_dout   (dev_dout)
    );

    assert_start_runs_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.go |=> evt.busy)
        else $error("start write did not start the engine");

endmodule

// File: tb/sim_sgdma_engine.sv
module sim_sgdma_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBL_LO = 32'h0000_4000;
    localparam int TBL_WORDS = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mrd_req, mrd_ack, mrd_err;
    logic [31:0] mrd_addr, mrd_data;
    logic        mwr_req, mwr_ack;
    logic [31:0] mwr_addr, mwr_data;
    logic [3:0]  mwr_be;
    logic        dev_req, dev_ack;
    logic [15:0] dev_din, dev_dout;
    logic        dev_irq = 1'b0;
    logic        irq;

    logic [31:0] tbl [0:TBL_WORDS-1];
    logic [31:0] exp_addr [0:15];
    int          exp_hw [0:15];
    int          nreg = 0;
    int          idx = 0, off = 0, beats = 0;
    bit          tomem = 1'b0;
    bit          nostall = 1'b0;
    bit          hold_chk = 1'b1;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] err_addr = 32'h1;
    logic [2:0]  stall = '0;
    logic [31:0] ea;
    int          checks = 0, fails = 0;
    bit          finished = 1'b0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= TBL_LO && a < TBL_LO + 32'(TBL_WORDS*4))
            return tbl[(a - TBL_LO) >> 2];
        return {a[17:2] ^ 16'hA5A5, a[17:2]};
    endfunction

    function automatic logic [15:0] dev_pat(input logic [31:0] a);
        return a[16:1] ^ 16'h3C96;
    endfunction

    always_comb ea = exp_addr[idx & 15] + 32'(2 * off);

    assign mrd_ack  = mrd_req & ~stall[0];
    assign mrd_data = mem_word(mrd_addr);
    assign mrd_err  = mrd_req & (mrd_addr == err_addr);
    assign mwr_ack  = mwr_req & ~stall[1];
    assign dev_ack  = dev_req & ~stall[2];
    assign dev_din  = dev_pat(ea);

    sgdma_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack),
        .mrd_data(mrd_data), .mrd_err(mrd_err),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
        .mwr_be(mwr_be), .mwr_ack(mwr_ack),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_din(dev_din),
        .dev_dout(dev_dout), .dev_irq(dev_irq), .irq(irq)
    );

    function automatic void chk(input bit ok, input string req, input string what,
                                input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endfunction

    function automatic void advance();
        beats++;
        off++;
        if (off >= exp_hw[idx & 15]) begin
            idx++;
            off = 0;
        end
    endfunction

    // stall pattern for the coming edge is chosen first, then the beat that edge completes is checked
    always @(negedge clk) begin
        logic rd_ok, wr_ok, dv_ok;
        logic [15:0] half;
        stall = nostall ? 3'b000 : 3'($urandom & $urandom);
        rd_ok = mrd_req & ~stall[0];
        wr_ok = mwr_req & ~stall[1];
        dv_ok = dev_req & ~stall[2];
        if (!rst) begin
            if (hold_pend && hold_chk)
                chk(mrd_req && mrd_addr == hold_addr, "R13", "read request held", mrd_addr, hold_addr);
            hold_pend = mrd_req && !rd_ok;
            hold_addr = mrd_addr;
            if (tomem && wr_ok) begin
                chk(mwr_addr == {ea[31:2], 2'b00}, "R2", "write address order", mwr_addr, {ea[31:2], 2'b00});
                chk(mwr_be == (ea[1] ? 4'b1100 : 4'b0011), "R4", "byte enables", 32'(mwr_be), ea[1] ? 32'hC : 32'h3);
                half = ea[1] ? mwr_data[31:16] : mwr_data[15:0];
                chk(half == dev_pat(ea), "R4", "written halfword", 32'(half), 32'(dev_pat(ea)));
                advance();
            end
            if (!tomem && dv_ok) begin
                half = ea[1] ? mem_word({ea[31:2], 2'b00})[31:16] : mem_word({ea[31:2], 2'b00})[15:0];
                chk(dev_dout == half, "R5", "halfword to device", 32'(dev_dout), 32'(half));
                advance();
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd1;
    endtask

    task automatic wait_idle();
        int n = 0;
        logic [31:0] s;
        do begin
            rd(2'd1, s);
            n++;
        end while (s[0] && n < 100000);
    endtask

    // fills a table; hw_fixed of zero picks random region lengths
    task automatic build(input logic [31:0] base, input int n, input int hw_fixed);
        int w;
        logic [31:0] a, cw;
        nreg = n;
        w = int'((base - TBL_LO) >> 2);
        for (int i = 0; i < n; i++) begin
            a = 32'h0010_0000 + 32'(i) * 32'h1000 + 32'($urandom % 64) * 4;
            exp_addr[i] = a;
            exp_hw[i] = (hw_fixed != 0) ? hw_fixed : 1 + int'($urandom % 8);
            cw = (32'(exp_hw[i]) << 1) | 32'($urandom % 2) | (($urandom & 32'h7FFF) << 16);
            if (i == n - 1) cw[31] = 1'b1;
            tbl[w + 2*i]     = a | 32'($urandom % 4);
            tbl[w + 2*i + 1] = cw;
        end
    endtask

    function automatic int total_hw();
        int t = 0;
        for (int i = 0; i < nreg; i++) t += exp_hw[i];
        return t;
    endfunction

    task automatic run(input bit dir, input logic [31:0] ptr, input int exp_beats,
                       input logic [31:0] exp_sts, input string req);
        logic [31:0] s;
        wr(2'd2, ptr);
        wr(2'd1, 32'h6);
        idx = 0; off = 0; beats = 0; tomem = dir;
        wr(2'd0, dir ? 32'h9 : 32'h1);
        wait_idle();
        chk(beats == exp_beats, req, "halfwords moved", 32'(beats), 32'(exp_beats));
        rd(2'd1, s);
        chk(s == exp_sts, req, "status after run", s, exp_sts);
        chk(irq == exp_sts[2], "R12", "irq follows latch", 32'(irq), 32'(exp_sts[2]));
        wr(2'd0, 32'h0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd20240517));
        for (int i = 0; i < TBL_WORDS; i++) tbl[i] = '0;
        for (int i = 0; i < 16; i++) begin exp_addr[i] = '0; exp_hw[i] = 1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, s); chk(s == 0, "R1", "command after reset", s, 0);
        rd(2'd1, s); chk(s == 0, "R1", "status after reset", s, 0);
        rd(2'd2, s); chk(s == 0, "R1", "pointer after reset", s, 0);
        chk({irq, mrd_req, mwr_req, dev_req} == 4'b0, "R1", "outputs idle",
            32'({irq, mrd_req, mwr_req, dev_req}), 0);

        // R2 R4 R5 R6 random tables both directions with random stalls
        for (int r = 0; r < 8; r++) begin
            build(TBL_LO + 32'(r) * 32'h80, 1 + int'($urandom % 5), 0);
            run(r[0], TBL_LO + 32'(r) * 32'h80, total_hw(), 32'h4, "R6");
        end

        // R11 sticky latch clear by one only
        wr(2'd1, 32'hFFFF_FFF9);
        rd(2'd1, s); chk(s == 32'h4, "R11", "zero written to latch bit", s, 32'h4);
        wr(2'd1, 32'h4);
        rd(2'd1, s); chk(s == 32'h0, "R11", "one written clears latch", s, 0);

        // R8 pointer low bits masked and honoured
        build(32'h0000_4800, 3, 0);
        wr(2'd2, 32'h0000_4803);
        rd(2'd2, s); chk(s == 32'h0000_4800, "R8", "pointer readback", s, 32'h4800);
        run(1'b0, 32'h0000_4803, total_hw(), 32'h4, "R8");

        // R7 second start write ignored, direction kept
        build(32'h0000_4400, 4, 8);
        wr(2'd2, 32'h0000_4400); wr(2'd1, 32'h6);
        idx = 0; off = 0; beats = 0; tomem = 1'b1;
        wr(2'd0, 32'h9);
        repeat (6) @(negedge clk);
        wr(2'd0, 32'h1);
        rd(2'd0, s); chk(s == 32'h9, "R7", "command unchanged by second start", s, 32'h9);
        wait_idle();
        chk(beats == 32, "R7", "transfer unaffected by second start", 32'(beats), 32);
        wr(2'd0, 32'h0);

        // R7 abort drops all state, restart begins at first descriptor
        hold_chk = 1'b0;
        wr(2'd1, 32'h6);
        idx = 0; off = 0; beats = 0; tomem = 1'b0;
        wr(2'd0, 32'h1);
        repeat (8) @(negedge clk);
        wr(2'd0, 32'h0);
        chk({mrd_req, mwr_req, dev_req} == 3'b0, "R7", "no request after stop",
            32'({mrd_req, mwr_req, dev_req}), 0);
        rd(2'd1, s); chk(s == 32'h0, "R7", "idle after stop", s, 0);
        idx = 0; off = 0; beats = 0;
        wr(2'd0, 32'h1);
        wait_idle();
        hold_chk = 1'b1;
        chk(beats == 32, "R7", "restart from table start", 32'(beats), 32);
        rd(2'd1, s); chk(s == 32'h4, "R7", "restart completes", s, 32'h4);
        wr(2'd0, 32'h0);

        // R9 table leaving its page
        build(32'h0000_4FF8, 2, 3);
        run(1'b1, 32'h0000_4FF8, 3, 32'h2, "R9");
        wr(2'd1, 32'hFFFF_FFFD);
        rd(2'd1, s); chk(s == 32'h2, "R11", "error latch kept", s, 32'h2);

        // R10 data read error and descriptor read error
        build(32'h0000_4600, 3, 4);
        err_addr = exp_addr[1];
        run(1'b0, 32'h0000_4600, 4, 32'h2, "R10");
        err_addr = 32'h0000_4600 + 32'd16;
        run(1'b1, 32'h0000_4600, 8, 32'h2, "R10");
        err_addr = 32'h1;
        wr(2'd1, 32'h2);
        rd(2'd1, s); chk(s == 32'h0, "R11", "error latch cleared", s, 0);

        // R12 device interrupt
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd(2'd1, s); chk(s == 32'h4, "R12", "device interrupt latched", s, 32'h4);
        chk(irq == 1'b1, "R12", "irq output", 32'(irq), 1);
        wr(2'd1, 32'h4);

        // R3 zero count means 64 KB
        nreg = 1;
        exp_addr[0] = 32'h0020_0000; exp_hw[0] = 32768;
        tbl[32'h200] = 32'h0020_0000;
        tbl[32'h201] = 32'h8000_0001;
        nostall = 1'b1;
        run(1'b1, 32'h0000_4800, 32768, 32'h4, "R3");
        nostall = 1'b0;

        finish_up();
    end

endmodule